// File: doc/BRIEF.md
# Dual interrupt-enable flag controller

This block holds the two interrupt-enable flags of a small 8-bit processor core. The primary flag gates maskable interrupts. The shadow flag keeps a saved copy of the primary flag while a non-maskable interrupt is being serviced. The core reports each completing instruction with a boundary strobe. In the same cycle it raises at most one decoded-operation strobe: enable, disable, return-from-NMI or load-from-special-register.

The block samples a level-sensitive maskable request and an edge-triggered non-maskable request. At an instruction boundary it decides whether to take an interrupt and drives a one-cycle accept pulse. The flag changes caused by an accept happen on the same clock edge as the pulse. For the load-from-special-register operation it gives the core a parity-flag value and a write strobe.

After an enable, maskable requests are held off for a set number of instruction boundaries. The count includes the enable's own boundary. The number is set by a parameter, and the default lets the instruction after the enable complete before an interrupt is taken.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, both flags, both accept outputs, `parity_we_o` and `parity_val_o` are 0.
- R2: At a boundary, enable sets both flags to 1 and disable clears both to 0. If several operation strobes are present, disable wins over enable, and enable wins over return.
- R3: Operation strobes (enable, disable, return, load) have no effect in a cycle where `insn_end_i` is low.
- R4: After an enable, maskable requests are refused at `HOLD_BOUNDARIES` boundaries, counting the enable's own boundary, and may be taken at the next one. A further enable restarts this window.
- R5: A maskable request (`irq_i` high at a boundary) is taken when the primary flag is 1, as left by that boundary's operation, and no hold window is active. Taking it clears both flags.
- R6: A rising edge of `nmi_i` is latched until a boundary, where it is taken whatever the flags are. Taking it clears the primary flag and loads the shadow flag with the primary value left by that boundary's operation.
- R7: If a non-maskable and a maskable interrupt could both be taken at one boundary, only the non-maskable one is taken.
- R8: Return-from-NMI at a boundary copies the shadow flag into the primary flag.
- R9: Load-from-special-register at a boundary gives a one-cycle `parity_we_o` pulse, with `parity_val_o` equal to the shadow flag from before that boundary. It changes neither flag.
- R10: `int_ack_o` and `nmi_ack_o` are one-cycle pulses, high in the cycle after the boundary that takes the interrupt, and never high together.
- R11: Only the primary flag gates maskable interrupts: with primary 0 and shadow 1, a maskable request is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_end_i | input | 1 | Instruction completes this cycle |
| op_en_i | input | 1 | Completing instruction enables interrupts |
| op_dis_i | input | 1 | Completing instruction disables interrupts |
| op_retn_i | input | 1 | Completing instruction returns from NMI |
| op_ldspec_i | input | 1 | Completing instruction loads from a special register |
| irq_i | input | 1 | Maskable request, level-sensitive |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| int_ack_o | output | 1 | Maskable interrupt taken (pulse) |
| nmi_ack_o | output | 1 | Non-maskable interrupt taken (pulse) |
| mask_flag_o | output | 1 | Primary enable flag |
| shadow_flag_o | output | 1 | Shadow enable flag |
| parity_val_o | output | 1 | Value for the core's parity flag |
| parity_we_o | output | 1 | Write strobe for the parity flag |

## Verification
The bench builds the block with `HOLD_BOUNDARIES` = 2. Both the enable's own boundary and the boundary after it are then refused, so the hold counter really counts down through a nonzero value. With that setting the bench can show that an enable given inside an active window reloads the count and does not shorten it.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  // Operation selected for the completing instruction
  typedef enum logic [1:0] {
    OPS_NONE = 2'd0,
    OPS_DIS  = 2'd1,
    OPS_EN   = 2'd2,
    OPS_RETN = 2'd3
  } op_sel_e;

  typedef struct packed {
    logic primary;
    logic shadow;
  } ie_flags_t;

endpackage

// File: rtl/irq_op_decode.sv
module irq_op_decode
  import irq_flag_pkg::*;
(
  input  logic    boundary_i,
  input  logic    en_i,
  input  logic    dis_i,
  input  logic    retn_i,
  output op_sel_e op_o
);
  // R2 priority: disable, then enable, then return. R3: nothing without a boundary.
  always_comb begin
    op_o = OPS_NONE;
    if (boundary_i) begin
      if (dis_i)       op_o = OPS_DIS;
      else if (en_i)   op_o = OPS_EN;
      else if (retn_i) op_o = OPS_RETN;
    end
  end
endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_i,
  input  logic take_i,
  output logic pending_o
);
  logic prev_q;
  logic pend_q;
  logic rise;

  assign rise      = nmi_i & ~prev_q;
  assign pending_o = pend_q | rise;

  // R6: an edge stays latched until it is taken at a boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_i;
      pend_q <= pending_o & ~take_i;
    end
  end
endmodule

// File: rtl/irq_enable_guard.sv
module irq_enable_guard #(
  parameter int HOLD_BOUNDARIES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic boundary_i,
  input  logic enable_op_i,
  output logic guard_o
);
  localparam int CNT_W = $clog2(HOLD_BOUNDARIES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_BOUNDARIES - 1);

  logic [CNT_W-1:0] cnt_q;

  // R4: the enable's own boundary is refused, then RELOAD more
  assign guard_o = enable_op_i | (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (boundary_i) begin
      if (enable_op_i)         cnt_q <= RELOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/irq_accept_arb.sv
module irq_accept_arb
  import irq_flag_pkg::*;
(
  input  logic      boundary_i,
  input  op_sel_e   op_i,
  input  ie_flags_t cur_i,
  input  logic      irq_i,
  input  logic      nmi_pend_i,
  input  logic      guard_i,
  output logic      int_take_o,
  output logic      nmi_take_o,
  output ie_flags_t next_o
);
  ie_flags_t post_op;

  // Flags as left by the completing instruction's operation
  always_comb begin
    post_op = cur_i;
    unique case (op_i)
      OPS_DIS:  post_op = '{primary: 1'b0, shadow: 1'b0};
      OPS_EN:   post_op = '{primary: 1'b1, shadow: 1'b1};
      OPS_RETN: post_op = '{primary: cur_i.shadow, shadow: cur_i.shadow};
      default:  post_op = cur_i;
    endcase
  end

  // R7: non-maskable wins; R5/R11: primary flag alone gates maskable
  assign nmi_take_o = boundary_i & nmi_pend_i;
  assign int_take_o = boundary_i & ~nmi_take_o & irq_i & post_op.primary & ~guard_i;

  always_comb begin
    if (nmi_take_o)      next_o = '{primary: 1'b0, shadow: post_op.primary};
    else if (int_take_o) next_o = '{primary: 1'b0, shadow: 1'b0};
    else                 next_o = post_op;
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int HOLD_BOUNDARIES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic insn_end_i,
  input  logic op_en_i,
  input  logic op_dis_i,
  input  logic op_retn_i,
  input  logic op_ldspec_i,
  input  logic irq_i,
  input  logic nmi_i,
  output logic int_ack_o,
  output logic nmi_ack_o,
  output logic mask_flag_o,
  output logic shadow_flag_o,
  output logic parity_val_o,
  output logic parity_we_o
);
  op_sel_e   op_sel;
  ie_flags_t flags_q;
  ie_flags_t flags_nx;
  logic      nmi_pend;
  logic      guard;
  logic      int_take;
  logic      nmi_take;
  logic      int_ack_q;
  logic      nmi_ack_q;
  logic      pval_q;
  logic      pwe_q;

  irq_op_decode u_dec (
    .boundary_i (insn_end_i),
    .en_i       (op_en_i),
    .dis_i      (op_dis_i),
    .retn_i     (op_retn_i),
    .op_o       (op_sel)
  );

  irq_nmi_latch u_nmi (
    .clk       (clk),
    .rst       (rst),
    .nmi_i     (nmi_i),
    .take_i    (nmi_take),
    .pending_o (nmi_pend)
  );

  irq_enable_guard #(
    .HOLD_BOUNDARIES (HOLD_BOUNDARIES)
  ) u_guard (
    .clk         (clk),
    .rst         (rst),
    .boundary_i  (insn_end_i),
    .enable_op_i (op_sel == OPS_EN),
    .guard_o     (guard)
  );

  irq_accept_arb u_arb (
    .boundary_i (insn_end_i),
    .op_i       (op_sel),
    .cur_i      (flags_q),
    .irq_i      (irq_i),
    .nmi_pend_i (nmi_pend),
    .guard_i    (guard),
    .int_take_o (int_take),
    .nmi_take_o (nmi_take),
    .next_o     (flags_nx)
  );

  // R1 reset; flags move only at boundaries (R3)
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q   <= '{primary: 1'b0, shadow: 1'b0};
      int_ack_q <= 1'b0;
      nmi_ack_q <= 1'b0;
      pval_q    <= 1'b0;
      pwe_q     <= 1'b0;
    end else begin
      if (insn_end_i) flags_q <= flags_nx;
      int_ack_q <= int_take;
      nmi_ack_q <= nmi_take;
      pwe_q     <= insn_end_i & op_ldspec_i;
      if (insn_end_i && op_ldspec_i) pval_q <= flags_q.shadow; // R9
    end
  end

  assign int_ack_o     = int_ack_q;
  assign nmi_ack_o     = nmi_ack_q;
  assign mask_flag_o   = flags_q.primary;
  assign shadow_flag_o = flags_q.shadow;
  assign parity_val_o  = pval_q;
  assign parity_we_o   = pwe_q;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic insn_end_i,
  input logic op_en_i,
  input logic op_dis_i,
  input logic op_retn_i,
  input logic op_ldspec_i,
  input logic int_ack_o,
  input logic nmi_ack_o,
  input logic mask_flag_o,
  input logic shadow_flag_o,
  input logic parity_val_o,
  input logic parity_we_o
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!mask_flag_o && !shadow_flag_o && !int_ack_o && !nmi_ack_o)); // R1
  AST_ACKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(int_ack_o && nmi_ack_o)); // R10
  AST_ACK_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (rst) (int_ack_o || nmi_ack_o) |-> $past(insn_end_i)); // R10
  AST_INT_ACK_PULSE: assert property (@(posedge clk) disable iff (rst) int_ack_o |=> !int_ack_o); // R10
  AST_INT_CLEARS_BOTH: assert property (@(posedge clk) disable iff (rst) int_ack_o |-> (!mask_flag_o && !shadow_flag_o)); // R5
  AST_INT_NEEDS_PRIMARY: assert property (@(posedge clk) disable iff (rst) int_ack_o |-> ($past(mask_flag_o) || $past(op_retn_i))); // R11
  AST_INT_NOT_ON_ENABLE: assert property (@(posedge clk) disable iff (rst) int_ack_o |-> !$past(op_en_i)); // R4
  AST_NMI_CLEARS_PRIMARY: assert property (@(posedge clk) disable iff (rst) nmi_ack_o |-> !mask_flag_o); // R6
  AST_PARITY_FROM_SHADOW: assert property (@(posedge clk) disable iff (rst) parity_we_o |-> (parity_val_o == $past(shadow_flag_o))); // R9
  AST_PARITY_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst) parity_we_o |-> $past(insn_end_i && op_ldspec_i)); // R9
  AST_FLAGS_HOLD_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (rst) !insn_end_i |=> ($stable(mask_flag_o) && $stable(shadow_flag_o))); // R3
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst) (insn_end_i && op_dis_i) |=> (!mask_flag_o && !shadow_flag_o)); // R2
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .insn_end_i    (insn_end_i),
  .op_en_i       (op_en_i),
  .op_dis_i      (op_dis_i),
  .op_retn_i     (op_retn_i),
  .op_ldspec_i   (op_ldspec_i),
  .int_ack_o     (int_ack_o),
  .nmi_ack_o     (nmi_ack_o),
  .mask_flag_o   (mask_flag_o),
  .shadow_flag_o (shadow_flag_o),
  .parity_val_o  (parity_val_o),
  .parity_we_o   (parity_we_o)
);

// File: tb/irq_flag_ctrl_tb_top.sv
module irq_flag_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic insn_end_i = 1'b0, op_en_i = 1'b0, op_dis_i = 1'b0, op_retn_i = 1'b0;
  logic op_ldspec_i = 1'b0, irq_i = 1'b0, nmi_i = 1'b0;
  logic int_ack_o, nmi_ack_o, mask_flag_o, shadow_flag_o, parity_val_o, parity_we_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  irq_flag_ctrl #(.HOLD_BOUNDARIES(2)) dut_i (
    .clk(clk), .rst(rst), .insn_end_i(insn_end_i), .op_en_i(op_en_i),
    .op_dis_i(op_dis_i), .op_retn_i(op_retn_i), .op_ldspec_i(op_ldspec_i),
    .irq_i(irq_i), .nmi_i(nmi_i), .int_ack_o(int_ack_o), .nmi_ack_o(nmi_ack_o),
    .mask_flag_o(mask_flag_o), .shadow_flag_o(shadow_flag_o),
    .parity_val_o(parity_val_o), .parity_we_o(parity_we_o)
  );

  // stim = {end, en, dis, retn, ld, irq, nmi}; expect = {iack, nack, primary, shadow, pwe, pval}
  typedef struct packed {
    logic [3:0] rq;
    logic [6:0] stim;
    logic [5:0] expect_v;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{4'd3,  7'b0100000, 6'b000000}, // R3 enable without boundary
    '{4'd2,  7'b1100000, 6'b001100}, // R2 enable
    '{4'd4,  7'b1000010, 6'b001100}, // R4 second held boundary
    '{4'd5,  7'b1000010, 6'b100000}, // R5 taken, both cleared
    '{4'd2,  7'b1100000, 6'b001100}, // R2 enable again
    '{4'd2,  7'b1010000, 6'b000000}, // R2 disable
    '{4'd5,  7'b1000010, 6'b000000}, // R5 primary 0, refused
    '{4'd2,  7'b1110000, 6'b000000}, // R2 disable beats enable
    '{4'd2,  7'b1100000, 6'b001100}, // R2 enable
    '{4'd4,  7'b1000000, 6'b001100}, // R4
    '{4'd4,  7'b1000000, 6'b001100}, // R4
    '{4'd6,  7'b0000001, 6'b001100}, // R6 edge latched, no boundary
    '{4'd6,  7'b1000001, 6'b010100}, // R6 taken, shadow keeps 1
    '{4'd10, 7'b0000001, 6'b000100}, // R10 pulse drops
    '{4'd11, 7'b1000011, 6'b000100}, // R11 shadow 1 does not enable
    '{4'd9,  7'b1000101, 6'b000111}, // R9 parity gets shadow 1
    '{4'd8,  7'b1001001, 6'b001101}, // R8 restore primary
    '{4'd6,  7'b0000000, 6'b001101}, // R6 request falls
    '{4'd7,  7'b1000011, 6'b010101}, // R7 NMI wins
    '{4'd8,  7'b1001011, 6'b100001}, // R8 restore, then maskable taken
    '{4'd4,  7'b1100000, 6'b001101}, // R4 enable
    '{4'd4,  7'b1100010, 6'b001101}, // R4 enable again restarts window
    '{4'd4,  7'b1000010, 6'b001101}, // R4 still held
    '{4'd4,  7'b1000010, 6'b100001}, // R4 window over, taken
    '{4'd9,  7'b1000100, 6'b000010}, // R9 parity gets shadow 0
    '{4'd3,  7'b0001100, 6'b000000}  // R3 return/load without boundary
  };

  function automatic logic [5:0] outs();
    return {int_ack_o, nmi_ack_o, mask_flag_o, shadow_flag_o, parity_we_o, parity_val_o};
  endfunction

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp_v);
    n_checks++;
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (iack nack pri sha pwe pval)", tag, got, exp_v);
    end
  endtask

  task automatic drive(input logic [6:0] s);
    {insn_end_i, op_en_i, op_dis_i, op_retn_i, op_ldspec_i, irq_i, nmi_i} = s;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 check("R1 reset", outs(), 6'b000000);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #2 check("R1 after release", outs(), 6'b000000);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk) drive(VEC[k].stim);
      @(posedge clk); #2;
      check($sformatf("R%0d vector %0d", VEC[k].rq, k), outs(), VEC[k].expect_v);
    end

    // R1 directed: reset with flags set clears everything
    @(negedge clk) drive(7'b1100000);
    @(posedge clk); #2 check("R2 enable before reset", outs(), 6'b001100);
    @(negedge clk) begin drive(7'b0000000); rst = 1'b1; end
    @(posedge clk); #2 check("R1 mid-run reset", outs(), 6'b000000);
    @(negedge clk) rst = 1'b0;

    // R6 directed: edge latched over several idle cycles
    @(negedge clk) drive(7'b0000001);
    @(negedge clk) drive(7'b0000000);
    repeat (3) @(negedge clk);
    @(posedge clk); #2 check("R6 still pending, no ack", outs(), 6'b000000);
    @(negedge clk) drive(7'b1000000);
    @(posedge clk); #2 check("R6 latched edge taken", outs(), 6'b010000);
    @(negedge clk) drive(7'b0000000);
    @(posedge clk); #2 check("R10 nmi pulse one cycle", outs(), 6'b000000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule